// File: doc/BRIEF.md
# Pixel Colour Key Generator

This block sits in front of a video mixer and decides, one pixel at a time, whether the mixer shows the internally generated video or an external overlay source. The decision comes from one of two places. In external mode the block samples a key input and applies a selectable polarity. In internal mode it gathers each pixel from one, two or three incoming bytes and compares every byte with a single 8-bit key value. The key fires only when all bytes of the pixel match.

A 3-bit mode field selects the source of the key and sets how many bytes make up a pixel. In one of the two-byte modes, one byte is taken on the falling clock edge and the other on the following rising edge. The other multi-byte modes take their bytes on rising edges only. A line-active input marks the active part of a line and restarts the byte count. Before the global enable gates it, the key passes through a delay of 0 to 7 pixel clocks. The output is a registered select line, so a change to the delay setting can only take effect at a clock edge.

Top module: `pixel_key_gen`

## Requirements
- R1: While keyEnable is 0 at a rising edge, overlaySel is 0 after that edge (generated video selected).
- R2: With keyMode 000, the key follows extKey as sampled at each rising edge. If keyInvert is 0, extKey high gives overlaySel 0 and extKey low gives overlaySel 1. If keyInvert is 1, the mapping is reversed. With keyDelay 0, overlaySel reflects the extKey sampled at that same edge.
- R3: keyMode codes 001, 010 and 011 give no key: overlaySel stays 0.
- R4: keyMode 100 takes one byte per rising edge as a whole pixel. The key is 1 when pixByte equals keyValue. With keyDelay 0, overlaySel shows the result one edge after the edge that sampled the byte.
- R5: keyMode 110 takes a pixel as two bytes on consecutive rising edges. The first byte is the one at the first rising edge with lineActive high. The key is 1 only if both bytes equal keyValue.
- R6: keyMode 101 takes a pixel as the byte present at a falling edge followed by the byte at the next rising edge. A pixel completes at every rising edge, and the key is 1 only if both bytes equal keyValue.
- R7: keyMode 111 takes a pixel as three bytes on consecutive rising edges. The key is 1 only if all three bytes equal keyValue.
- R8: The internal key holds its value from one pixel completion to the next. A rising edge with lineActive low clears the internal key and restarts byte counting.
- R9: keyDelay d (0 to 7) makes overlaySel after edge n equal to the ungated key value presented at edge n-d.
- R10: A new keyDelay value takes effect at the next rising edge. overlaySel changes only at rising edges.
- R11: While rstN is low, overlaySel is 0, the internal key is 0 and the byte count is at the start of a pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineActive | input | 1 | High during active video; low clears pixel assembly |
| pixByte | input | 8 | Incoming pixel byte |
| extKey | input | 1 | External key input |
| keyEnable | input | 1 | Global keying enable |
| keyInvert | input | 1 | External key polarity select |
| keyMode | input | 3 | Key source and pixel assembly mode |
| keyValue | input | 8 | Key compare value |
| keyDelay | input | 3 | Key delay in pixel clocks (0 to 7) |
| overlaySel | output | 1 | 1 selects the overlay source, 0 selects generated video |

## Verification
Several functions can act in the same cycle. A pixel can complete at the same edge that lineActive drops, the mode field changes, or keyDelay moves its tap. In each case the clear, the new assembly length or the new tap has to win over the old one in exactly that cycle. The random phase provokes these collisions on purpose. It changes mode, delay and enable every few dozen cycles with no regard to pixel boundaries, and it drops lineActive at random points. A per-edge reference model built from the requirements then judges every output cycle.

// File: rtl/pixkey_pkg.sv
package pixkey_pkg;
  localparam int BYTE_W  = 8;
  localparam int MODE_W  = 3;

  localparam logic [MODE_W-1:0] MODE_EXTERNAL = 3'b000;
  localparam logic [MODE_W-1:0] MODE_SINGLE   = 3'b100;
  localparam logic [MODE_W-1:0] MODE_DUALEDGE = 3'b101;
  localparam logic [MODE_W-1:0] MODE_TWOBYTE  = 3'b110;
  localparam logic [MODE_W-1:0] MODE_THREE    = 3'b111;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic lineOn;      // line active this edge
    logic closePixel;  // last byte of a pixel is at the input
    logic dualEdge;    // falling-edge byte is part of the pixel
    logic useExt;      // external key source
    logic useInt;      // internal compare source
  } keyStrobes_t;
endpackage

// File: rtl/pixkey_ctrl.sv
module pixkey_ctrl
  import pixkey_pkg::*;
#(
  parameter int PHASE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineActive,
  input  logic [MODE_W-1:0] keyMode,
  output keyStrobes_t       strobes
);
  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] lastIdx;
  logic               closeNow;

  always_comb begin
    case (keyMode)
      MODE_TWOBYTE: lastIdx = PHASE_W'(1);
      MODE_THREE:   lastIdx = PHASE_W'(2);
      default:      lastIdx = '0;
    endcase
  end

  assign closeNow = lineActive && (phase >= lastIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
    end else if (!lineActive || closeNow) begin
      phase <= '0;
    end else begin
      phase <= phase + PHASE_W'(1);
    end
  end

  always_comb begin
    strobes.lineOn     = lineActive;
    strobes.closePixel = closeNow;
    strobes.dualEdge   = (keyMode == MODE_DUALEDGE);
    strobes.useExt     = (keyMode == MODE_EXTERNAL);
    strobes.useInt     = keyMode[MODE_W-1];
  end
endmodule

// File: rtl/pixkey_datapath.sv
module pixkey_datapath
  import pixkey_pkg::*;
#(
  parameter int DATA_W = BYTE_W,
  parameter int DLY_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  keyStrobes_t       strobes,
  input  logic [DATA_W-1:0] pixByte,
  input  logic              extKey,
  input  logic              keyEnable,
  input  logic              keyInvert,
  input  logic [DATA_W-1:0] keyValue,
  input  logic [DLY_W-1:0]  keyDelay,
  output logic              overlaySel,
  output logic              pixKey
);
  localparam int TAPS   = 1 << DLY_W;
  localparam int STAGES = TAPS - 1;

  logic [DATA_W-1:0] fallByte;
  logic              matchAcc;
  logic              byteHit;
  logic              keyRaw;
  logic [STAGES-1:0] dlyLine;
  logic [TAPS-1:0]   tapVec;

  // byte presented at the falling edge (first half of a dual-edge pixel)
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) fallByte <= '0;
    else       fallByte <= pixByte;
  end

  assign byteHit = (pixByte == keyValue) &&
                   (!strobes.dualEdge || (fallByte == keyValue));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchAcc <= 1'b1;
      pixKey   <= 1'b0;
    end else if (!strobes.lineOn) begin
      matchAcc <= 1'b1;
      pixKey   <= 1'b0;
    end else if (strobes.closePixel) begin
      matchAcc <= 1'b1;
      pixKey   <= matchAcc && byteHit;
    end else begin
      matchAcc <= matchAcc && byteHit;
    end
  end

  always_comb begin
    if (strobes.useExt)      keyRaw = keyInvert ? extKey : !extKey;
    else if (strobes.useInt) keyRaw = pixKey;
    else                     keyRaw = 1'b0;
  end

  // delay stages, stage 0 holds the newest value
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) dlyLine[g] <= 1'b0;
      else if (g == 0) dlyLine[g] <= keyRaw;
      else             dlyLine[g] <= dlyLine[(g == 0) ? 0 : g-1];
    end
  end

  assign tapVec = {dlyLine, keyRaw};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) overlaySel <= 1'b0;
    else       overlaySel <= keyEnable && tapVec[keyDelay];
  end
endmodule

// File: rtl/pixel_key_gen.sv
module pixel_key_gen
  import pixkey_pkg::*;
#(
  parameter int DATA_W = BYTE_W,
  parameter int DLY_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineActive,
  input  logic [DATA_W-1:0] pixByte,
  input  logic              extKey,
  input  logic              keyEnable,
  input  logic              keyInvert,
  input  logic [MODE_W-1:0] keyMode,
  input  logic [DATA_W-1:0] keyValue,
  input  logic [DLY_W-1:0]  keyDelay,
  output logic              overlaySel
);
  keyStrobes_t strobes;
  logic        pixKey;

  pixkey_ctrl #(.PHASE_W(2)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lineActive (lineActive),
    .keyMode    (keyMode),
    .strobes    (strobes)
  );

  pixkey_datapath #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .pixByte    (pixByte),
    .extKey     (extKey),
    .keyEnable  (keyEnable),
    .keyInvert  (keyInvert),
    .keyValue   (keyValue),
    .keyDelay   (keyDelay),
    .overlaySel (overlaySel),
    .pixKey     (pixKey)
  );
endmodule

// File: rtl/pixkey_checker.sv
module pixkey_checker #(
  parameter int DLY_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             keyEnable,
  input logic             keyInvert,
  input logic [2:0]       keyMode,
  input logic [DLY_W-1:0] keyDelay,
  input logic             extKey,
  input logic             overlaySel,
  input logic             closePixel,
  input logic             lineOn,
  input logic             pixKey
);
  // R1: disabled keying selects generated video
  a_r1_enable_off: assert property (@(posedge clk) disable iff (!rstN)
    !keyEnable |=> !overlaySel);

  // R2: external key polarity with no delay
  a_r2_external_polarity: assert property (@(posedge clk) disable iff (!rstN)
    (keyEnable && keyMode == 3'b000 && keyDelay == '0) |=>
      (overlaySel == ($past(keyInvert) ? $past(extKey) : !$past(extKey))));

  // R7: three-byte pixels never complete on adjacent edges
  a_r7_three_byte_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (closePixel && keyMode == 3'b111) |=> !(closePixel && keyMode == 3'b111));

  // R8: internal key holds between pixel completions
  a_r8_pixel_hold: assert property (@(posedge clk) disable iff (!rstN)
    (lineOn && !closePixel) |=> $stable(pixKey));
endmodule

bind pixel_key_gen pixkey_checker #(.DLY_W(DLY_W)) u_pixkey_checker (
  .clk        (clk),
  .rstN       (rstN),
  .keyEnable  (keyEnable),
  .keyInvert  (keyInvert),
  .keyMode    (keyMode),
  .keyDelay   (keyDelay),
  .extKey     (extKey),
  .overlaySel (overlaySel),
  .closePixel (strobes.closePixel),
  .lineOn     (strobes.lineOn),
  .pixKey     (pixKey)
);

// File: tb/pixel_key_gen_bench.sv
module pixel_key_gen_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineActive = 1'b0;
  logic [7:0] pixByte = '0;
  logic       extKey = 1'b0;
  logic       keyEnable = 1'b0;
  logic       keyInvert = 1'b0;
  logic [2:0] keyMode = '0;
  logic [7:0] keyValue = '0;
  logic [2:0] keyDelay = '0;
  logic       overlaySel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int       mPh = 0;
  bit       mAcc = 1;
  bit       mPk = 0;
  bit [6:0] mHist = '0;

  always #4 clk = ~clk;

  pixel_key_gen u_pixel_key_gen (
    .clk(clk), .rstN(rstN), .lineActive(lineActive), .pixByte(pixByte),
    .extKey(extKey), .keyEnable(keyEnable), .keyInvert(keyInvert),
    .keyMode(keyMode), .keyValue(keyValue), .keyDelay(keyDelay),
    .overlaySel(overlaySel)
  );

  function automatic int bytesPerPixel(input logic [2:0] m);
    if (m == 3'b110) return 2;
    if (m == 3'b111) return 3;
    return 1;
  endfunction

  function automatic string modeTag(input logic [2:0] m, input logic en);
    if (!en) return "R1";
    case (m)
      3'b000: return "R2";
      3'b100: return "R4";
      3'b101: return "R6";
      3'b110: return "R5";
      3'b111: return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: overlaySel actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one pixel clock: fb is on the bus at the falling edge, rb at the rising edge
  task automatic cyc(input logic [7:0] fb, input logic [7:0] rb,
                     input logic ext, input logic la, input string tagIn);
    bit raw, exp, hit;
    bit [7:0] taps;
    string tag;
    pixByte = fb; extKey = ext; lineActive = la;
    @(negedge clk); #1;
    pixByte = rb;
    @(posedge clk); #1;
    if (keyMode == 3'b000)   raw = keyInvert ? ext : !ext;
    else if (keyMode[2])     raw = mPk;
    else                     raw = 0;
    taps = {mHist, raw};
    exp = keyEnable && taps[keyDelay];
    mHist = {mHist[5:0], raw};
    hit = (rb == keyValue) && (keyMode != 3'b101 || fb == keyValue);
    if (!la) begin
      mPh = 0; mAcc = 1; mPk = 0;
    end else if (mPh >= bytesPerPixel(keyMode) - 1) begin
      mPk = mAcc && hit; mAcc = 1; mPh = 0;
    end else begin
      mAcc = mAcc && hit; mPh++;
    end
    tag = (tagIn != "") ? tagIn : modeTag(keyMode, keyEnable);
    check(tag, overlaySel, exp);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240);
    // R11: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R11", overlaySel, 1'b0);
    keyEnable = 1; keyMode = 3'b000;
    @(posedge clk); #1;
    check("R11", overlaySel, 1'b0);
    keyEnable = 0;
    rstN = 1;

    // R2 directed: polarity both ways
    keyEnable = 1; keyMode = 3'b000; keyDelay = 0; keyInvert = 0;
    cyc(8'h00, 8'h00, 1, 1, "R2");
    cyc(8'h00, 8'h00, 0, 1, "R2");
    keyInvert = 1;
    cyc(8'h00, 8'h00, 1, 1, "R2");
    cyc(8'h00, 8'h00, 0, 1, "R2");

    // R7 directed: full match then one mismatching byte
    keyInvert = 0; keyMode = 3'b111; keyValue = 8'h5A;
    cyc(8'h00, 8'h00, 0, 0, "R8");
    for (int i = 0; i < 3; i++) cyc(8'h00, 8'h5A, 0, 1, "R7");
    cyc(8'h00, 8'h5A, 0, 1, "R7");
    cyc(8'h00, 8'h00, 0, 1, "R7");
    cyc(8'h00, 8'h5A, 0, 1, "R7");
    for (int i = 0; i < 3; i++) cyc(8'h00, 8'h5A, 0, 1, "R7");

    // R6 directed: falling byte mismatch blocks the key
    keyMode = 3'b101;
    cyc(8'h5A, 8'h5A, 0, 1, "R6");
    cyc(8'h11, 8'h5A, 0, 1, "R6");
    cyc(8'h5A, 8'h5A, 0, 1, "R6");
    cyc(8'h5A, 8'h5A, 0, 1, "R6");

    // R8 directed: line drop clears key mid-pixel
    keyMode = 3'b100;
    cyc(8'h00, 8'h5A, 0, 1, "R4");
    cyc(8'h00, 8'h5A, 0, 0, "R8");
    cyc(8'h00, 8'h5A, 0, 0, "R8");

    // R9/R10 directed: delay change on an external pulse train
    keyMode = 3'b000; keyDelay = 3'd7;
    for (int i = 0; i < 10; i++) cyc(8'h00, 8'h00, (i % 3) == 0, 1, "R9");
    keyDelay = 3'd2;
    for (int i = 0; i < 6; i++) cyc(8'h00, 8'h00, (i % 2) == 0, 1, "R10");

    // R3 directed
    keyMode = 3'b010; keyDelay = 0;
    for (int i = 0; i < 4; i++) cyc(8'h5A, 8'h5A, 0, 1, "R3");

    // random segments
    for (int seg = 0; seg < 80; seg++) begin
      keyMode   = 3'($urandom_range(0, 7));
      keyEnable = ($urandom_range(0, 5) != 0);
      keyInvert = 1'($urandom_range(0, 1));
      keyDelay  = 3'($urandom_range(0, 7));
      keyValue  = 8'($urandom_range(0, 255));
      for (int c = 0; c < 40; c++) begin
        logic [7:0] fb, rb;
        fb = ($urandom_range(0, 3) != 0) ? keyValue : 8'($urandom);
        rb = ($urandom_range(0, 3) != 0) ? keyValue : 8'($urandom);
        if (c == 20 && seg[0]) keyDelay = 3'($urandom_range(0, 7));
        cyc(fb, rb, 1'($urandom_range(0, 1)), $urandom_range(0, 11) != 0,
            (keyDelay != 0 && keyEnable) ? "R9" : "");
      end
    end
    finishRun();
  end
endmodule